// File: doc/BRIEF.md
# Multiload Page Copier

This block brings one program load out of a bank of stored load images and into a 6 KB working RAM made of three 2 KB banks. Each stored image is 8448 bytes long: 32 data pages of 256 bytes, followed by a 256-byte header. A caller gives a load number and the number of images present, then pulses start. The block reads the load number out of each header in turn until one matches. It checks the header's own checksum, then walks the header's page list. Each listed data page goes to the RAM bank and page named by its descriptor, and the page's checksum is verified as it streams through.

Checksum failures raise sticky flags but never stop the copy. A miss on every image raises a not-found flag and leaves the RAM untouched. When a load finishes, three parameter bytes from its header are presented for the caller to use as start-up values. The image memory is read through a synchronous port with one cycle of latency, and page data moves at one byte per clock once a page transfer is under way.

Top module: `mload_page_copier`

## Requirements
- R1: Images are searched from image 0 upward, only indices below `num_images` are considered, and the first image whose header byte at offset 5 equals `load_id` is the one loaded.
- R2: `hdr_bad` is high at `done` when the 8-bit wrapping sum of header bytes 0 to 7 of the chosen image differs from 0x55, and low when it equals 0x55; the load continues either way.
- R3: For page j (j counted from 0), the descriptor is header byte 16+j; bits 1:0 are the target bank and bits 4:2 the page in that bank, while bits 7:5 play no part in placement. All 256 bytes of data page j (image bytes j*256 to j*256+255) are written to RAM address bank*2048 + page*256 + n, in rising order of n.
- R4: The page check passes when the 8-bit wrapping sum of the page's 256 data bytes, its descriptor and its check byte (header byte 64+j) is 0x55. Any failing page sets `page_bad` by `done`, and the failing page is still written.
- R5: A page whose descriptor bank field is 3 produces no RAM write at all.
- R6: When a matching load completes, `hdr_p0`, `hdr_p1` and `hdr_p2` show header bytes 0, 1 and 2 of that image in the `done` cycle and hold them until the next completed load. A header page count of 0 completes with no RAM writes.
- R7: If no image matches, or `num_images` is 0, `not_found` is high at `done` and no RAM write occurs.
- R8: `busy` rises on the cycle after an accepted start and falls on the cycle after the single-cycle `done` pulse; a start pulse while busy is ignored and produces no second `done`.
- R9: Within one page, RAM writes come on consecutive clock cycles, 256 in a row, with the address rising by one each cycle.
- R10: The page count is taken from header byte 3 and limited to 32; a larger value copies data pages 0 to 31 only.
- R11: After reset, `busy`, `done`, `ram_we`, all flags and all parameter outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| start | input | 1 | Single-cycle request to begin a load |
| load_id | input | 8 | Load number to search for |
| num_images | input | NUM_W (3) | Number of images present in the image memory |
| img_addr | output | IMG_AW (16) | Byte address into the image memory |
| img_rdata | input | 8 | Image memory data, valid one cycle after the address |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | 13 | RAM byte address (bank, page, byte) |
| ram_wdata | output | 8 | RAM write data |
| busy | output | 1 | A load is in progress |
| done | output | 1 | One-cycle pulse at the end of a load |
| not_found | output | 1 | No image matched the request |
| hdr_bad | output | 1 | Header checksum mismatch |
| page_bad | output | 1 | At least one page checksum mismatch |
| hdr_p0 | output | 8 | Header byte 0 of the completed load |
| hdr_p1 | output | 8 | Header byte 1 of the completed load |
| hdr_p2 | output | 8 | Header byte 2 of the completed load |

## Verification
A scoreboard fills a queue with every RAM write that the chosen image's header implies and compares each write as it appears. A wrong image index, a wrong base offset or a corrupted descriptor therefore shows up on the first write of the first page, at most a few hundred cycles after start. A broken running sum or page counter reveals itself only at `done`, as a wrong flag, a missing or extra page, or a queue that is not empty. Runs with a doubled load number, a ROM-bank descriptor, planted checksum faults and an oversized page count set the expected data apart from what a plausible fault would produce.

// File: rtl/mload_pkg.sv
package mload_pkg;

  // Geometry of one stored image
  localparam int PAGE_BYTES  = 256;
  localparam int DATA_PAGES  = 32;
  localparam int HDR_OFS     = DATA_PAGES * PAGE_BYTES;
  localparam int HDR_BYTES   = 256;
  localparam int IMG_BYTES   = HDR_OFS + HDR_BYTES;

  // Header field offsets
  localparam int HDR_NPG     = 3;
  localparam int HDR_ID      = 5;
  localparam int HDR_SUM_LEN = 8;
  localparam int DESC_BASE   = 16;
  localparam int CHK_BASE    = 64;

  // Target RAM: bank(2) + page(3) + byte(8)
  localparam int RAM_AW      = 13;

  localparam logic [7:0] SUM_TARGET = 8'h55;
  localparam logic [1:0] ROM_BANK   = 2'b11;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SCAN_GO,
    ST_SCAN_WT,
    ST_HDR_GO,
    ST_HDR_WT,
    ST_HDR_EV,
    ST_DSC_GO,
    ST_DSC_WT,
    ST_CHK_GO,
    ST_CHK_WT,
    ST_DAT_GO,
    ST_DAT_WT,
    ST_PG_EV,
    ST_FIN
  } ld_state_t;

endpackage

// File: rtl/mload_reader.sv
// Issues a run of consecutive byte addresses, one per cycle, to a
// synchronous memory and tags the returning data with its index.
module mload_reader #(
  parameter  int AW      = 16,
  parameter  int MAX_LEN = 256,
  localparam int LW      = $clog2(MAX_LEN + 1),
  localparam int IW      = $clog2(MAX_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [AW-1:0] base,
  input  logic [LW-1:0] len,
  output logic [AW-1:0] mem_addr,
  input  logic [7:0]    mem_data,
  output logic          busy,
  output logic          d_valid,
  output logic [7:0]    d_byte,
  output logic [IW-1:0] d_idx,
  output logic          d_last
);

  logic          act_q, act_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [LW-1:0] cnt_q, cnt_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          v_q, v_d;
  logic [IW-1:0] ti_q, ti_d;
  logic          l_q, l_d;

  always_comb begin
    act_d  = act_q;
    addr_d = addr_q;
    cnt_d  = cnt_q;
    idx_d  = idx_q;
    if (go && !act_q) begin
      act_d  = 1'b1;
      addr_d = base;
      cnt_d  = len;
      idx_d  = '0;
    end else if (act_q) begin
      addr_d = addr_q + AW'(1);
      cnt_d  = cnt_q - LW'(1);
      idx_d  = idx_q + IW'(1);
      act_d  = (cnt_q != LW'(1));
    end
    v_d  = act_q;
    ti_d = idx_q;
    l_d  = act_q && (cnt_q == LW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      addr_q <= '0;
      cnt_q  <= '0;
      idx_q  <= '0;
    end else begin
      act_q  <= act_d;
      addr_q <= addr_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q  <= 1'b0;
      ti_q <= '0;
      l_q  <= 1'b0;
    end else begin
      v_q  <= v_d;
      ti_q <= ti_d;
      l_q  <= l_d;
    end
  end

  assign mem_addr = addr_q;
  assign busy     = act_q;
  assign d_valid  = v_q;
  assign d_byte   = mem_data;
  assign d_idx    = ti_q;
  assign d_last   = l_q;

  // R9
  addr_stride_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && $past(act_q)) |-> (mem_addr == $past(mem_addr) + AW'(1)));

  // R9
  last_has_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    d_last |-> d_valid);

endmodule

// File: rtl/mload_sum8.sv
// Wrapping 8-bit accumulator with a fixed-target compare.
module mload_sum8 import mload_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       en,
  input  logic [7:0] val,
  output logic       ok
);

  logic [7:0] sum_q, sum_d;
  logic       sum_en;

  assign sum_en = clr || en;

  always_comb begin
    if (clr) sum_d = 8'h00;
    else     sum_d = sum_q + val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sum_q <= 8'h00;
    else if (sum_en) sum_q <= sum_d;
  end

  assign ok = (sum_q == SUM_TARGET);

endmodule

// File: rtl/mload_page_copier.sv
module mload_page_copier import mload_pkg::*; #(
  parameter  int MAX_IMAGES = 4,
  localparam int NUM_W      = $clog2(MAX_IMAGES + 1),
  localparam int IMG_AW     = $clog2(MAX_IMAGES * IMG_BYTES),
  localparam int RD_LW      = $clog2(PAGE_BYTES + 1),
  localparam int RD_IW      = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [7:0]        load_id,
  input  logic [NUM_W-1:0]  num_images,
  output logic [IMG_AW-1:0] img_addr,
  input  logic [7:0]        img_rdata,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [7:0]        ram_wdata,
  output logic              busy,
  output logic              done,
  output logic              not_found,
  output logic              hdr_bad,
  output logic              page_bad,
  output logic [7:0]        hdr_p0,
  output logic [7:0]        hdr_p1,
  output logic [7:0]        hdr_p2
);

  ld_state_t st_q, st_d;

  logic [7:0]        id_q;
  logic [NUM_W-1:0]  num_q, idx_q;
  logic [IMG_AW-1:0] base_q, hdr_base;
  logic [5:0]        pg_q, npg_q;
  logic [4:0]        desc_q;
  logic [7:0]        cap0_q, cap1_q, cap2_q;
  logic              nf_q, hb_q, pb_q;
  logic [7:0]        p0_q, p1_q, p2_q;
  logic              we_q;
  logic [RAM_AW-1:0] wa_q;
  logic [7:0]        wd_q;

  // Reader and checksum hookup
  logic              rd_go, rd_busy;
  logic [IMG_AW-1:0] rd_base;
  logic [RD_LW-1:0]  rd_len;
  logic              d_valid, d_last;
  logic [7:0]        d_byte;
  logic [RD_IW-1:0]  d_idx;
  logic              s_clr, s_en, s_ok;

  // Decoded events
  logic accept, scan_miss, hdr_cap, wr_hit, load_fin, pg_adv;

  assign hdr_base  = base_q + IMG_AW'(HDR_OFS);
  assign accept    = (st_q == ST_IDLE) && start;
  assign scan_miss = (st_q == ST_SCAN_WT) && d_valid && (d_byte != id_q);
  assign hdr_cap   = (st_q == ST_HDR_WT) && d_valid;
  assign wr_hit    = (st_q == ST_DAT_WT) && d_valid && (desc_q[1:0] != ROM_BANK);
  assign pg_adv    = (st_q == ST_PG_EV);
  assign load_fin  = ((st_q == ST_HDR_EV) || (st_q == ST_PG_EV)) && (st_d == ST_FIN);

  mload_reader #(.AW(IMG_AW), .MAX_LEN(PAGE_BYTES)) u_reader (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (rd_go),
    .base     (rd_base),
    .len      (rd_len),
    .mem_addr (img_addr),
    .mem_data (img_rdata),
    .busy     (rd_busy),
    .d_valid  (d_valid),
    .d_byte   (d_byte),
    .d_idx    (d_idx),
    .d_last   (d_last)
  );

  mload_sum8 u_sum (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (s_clr),
    .en    (s_en),
    .val   (d_byte),
    .ok    (s_ok)
  );

  assign s_en = d_valid && ((st_q == ST_HDR_WT) || (st_q == ST_DSC_WT) ||
                            (st_q == ST_CHK_WT) || (st_q == ST_DAT_WT));

  // Next-state and read-request logic
  always_comb begin
    st_d    = st_q;
    rd_go   = 1'b0;
    rd_base = hdr_base;
    rd_len  = RD_LW'(1);
    s_clr   = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) st_d = (num_images == '0) ? ST_FIN : ST_SCAN_GO;
      end
      ST_SCAN_GO: begin
        rd_go   = 1'b1;
        rd_base = hdr_base + IMG_AW'(HDR_ID);
        st_d    = ST_SCAN_WT;
      end
      ST_SCAN_WT: begin
        if (d_valid) begin
          if (d_byte == id_q)                  st_d = ST_HDR_GO;
          else if (idx_q + NUM_W'(1) == num_q) st_d = ST_FIN;
          else                                 st_d = ST_SCAN_GO;
        end
      end
      ST_HDR_GO: begin
        rd_go  = 1'b1;
        rd_len = RD_LW'(HDR_SUM_LEN);
        s_clr  = 1'b1;
        st_d   = ST_HDR_WT;
      end
      ST_HDR_WT: begin
        if (d_valid && d_last) st_d = ST_HDR_EV;
      end
      ST_HDR_EV: begin
        st_d = (npg_q == '0) ? ST_FIN : ST_DSC_GO;
      end
      ST_DSC_GO: begin
        rd_go   = 1'b1;
        rd_base = hdr_base + IMG_AW'(DESC_BASE) + IMG_AW'(pg_q);
        s_clr   = 1'b1;
        st_d    = ST_DSC_WT;
      end
      ST_DSC_WT: begin
        if (d_valid) st_d = ST_CHK_GO;
      end
      ST_CHK_GO: begin
        rd_go   = 1'b1;
        rd_base = hdr_base + IMG_AW'(CHK_BASE) + IMG_AW'(pg_q);
        st_d    = ST_CHK_WT;
      end
      ST_CHK_WT: begin
        if (d_valid) st_d = ST_DAT_GO;
      end
      ST_DAT_GO: begin
        rd_go   = 1'b1;
        rd_base = base_q + IMG_AW'({pg_q[4:0], 8'h00});
        rd_len  = RD_LW'(PAGE_BYTES);
        st_d    = ST_DAT_WT;
      end
      ST_DAT_WT: begin
        if (d_valid && d_last) st_d = ST_PG_EV;
      end
      ST_PG_EV: begin
        st_d = (pg_q + 6'd1 == npg_q) ? ST_FIN : ST_DSC_GO;
      end
      ST_FIN:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  // Request capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q  <= '0;
      num_q <= '0;
    end else if (accept) begin
      id_q  <= load_id;
      num_q <= num_images;
    end
  end

  // Image walk
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      base_q <= '0;
    end else if (accept) begin
      idx_q  <= '0;
      base_q <= '0;
    end else if (scan_miss) begin
      idx_q  <= idx_q + NUM_W'(1);
      base_q <= base_q + IMG_AW'(IMG_BYTES);
    end
  end

  // Header field capture, page count limited to the data pages present
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap0_q <= '0;
      cap1_q <= '0;
      cap2_q <= '0;
      npg_q  <= '0;
    end else if (hdr_cap) begin
      case (d_idx)
        8'd0: cap0_q <= d_byte;
        8'd1: cap1_q <= d_byte;
        8'd2: cap2_q <= d_byte;
        8'(HDR_NPG): npg_q <= (d_byte > 8'(DATA_PAGES)) ? 6'(DATA_PAGES) : d_byte[5:0];
        default: ;
      endcase
    end
  end

  // Page walk
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   pg_q <= '0;
    else if (st_q == ST_HDR_GO)   pg_q <= '0;
    else if (pg_adv)              pg_q <= pg_q + 6'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             desc_q <= '0;
    else if ((st_q == ST_DSC_WT) && d_valid) desc_q <= d_byte[4:0];
  end

  // Status flags, cleared when a new request is accepted
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nf_q <= 1'b0;
      hb_q <= 1'b0;
      pb_q <= 1'b0;
    end else if (accept) begin
      nf_q <= (num_images == '0);
      hb_q <= 1'b0;
      pb_q <= 1'b0;
    end else begin
      if (scan_miss && (st_d == ST_FIN)) nf_q <= 1'b1;
      if (st_q == ST_HDR_EV)             hb_q <= !s_ok;
      if (pg_adv && !s_ok)               pb_q <= 1'b1;
    end
  end

  // Parameter outputs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p0_q <= '0;
      p1_q <= '0;
      p2_q <= '0;
    end else if (load_fin) begin
      p0_q <= cap0_q;
      p1_q <= cap1_q;
      p2_q <= cap2_q;
    end
  end

  // RAM write port register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) we_q <= 1'b0;
    else        we_q <= wr_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wa_q <= '0;
      wd_q <= '0;
    end else if (wr_hit) begin
      wa_q <= {desc_q[1:0], desc_q[4:2], d_idx};
      wd_q <= d_byte;
    end
  end

  assign ram_we    = we_q;
  assign ram_addr  = wa_q;
  assign ram_wdata = wd_q;
  assign busy      = (st_q != ST_IDLE);
  assign done      = (st_q == ST_FIN);
  assign not_found = nf_q;
  assign hdr_bad   = hb_q;
  assign page_bad  = pb_q;
  assign hdr_p0    = p0_q;
  assign hdr_p1    = p1_q;
  assign hdr_p2    = p2_q;

  // R8
  done_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  // R8
  busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  // R5
  no_rom_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (ram_addr[RAM_AW-1 -: 2] != ROM_BANK));

  // R7
  miss_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    not_found |-> !ram_we);

  // R9
  write_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && $past(ram_we)) |-> (ram_addr == $past(ram_addr) + RAM_AW'(1)));

  // R9
  reader_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |-> !rd_busy);

endmodule

// File: tb/tb_mload_page_copier.sv
module tb_mload_page_copier;

  localparam int NIMG = 4;
  localparam int IMGB = 8448;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  load_id = 8'h00;
  logic [2:0]  num_images = 3'd0;
  logic [15:0] img_addr;
  logic [7:0]  img_rdata;
  logic        ram_we;
  logic [12:0] ram_addr;
  logic [7:0]  ram_wdata;
  logic        busy, done, not_found, hdr_bad, page_bad;
  logic [7:0]  hdr_p0, hdr_p1, hdr_p2;

  always #5 clk = ~clk;

  mload_page_copier dut (
    .clk(clk), .rst_n(rst_n), .start(start), .load_id(load_id),
    .num_images(num_images), .img_addr(img_addr), .img_rdata(img_rdata),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .busy(busy), .done(done), .not_found(not_found), .hdr_bad(hdr_bad),
    .page_bad(page_bad), .hdr_p0(hdr_p0), .hdr_p1(hdr_p1), .hdr_p2(hdr_p2)
  );

  // Scenario tables
  logic [7:0] lid  [NIMG];
  int         npgs [NIMG];
  logic [7:0] dsc  [NIMG][40];
  logic [7:0] hbad [NIMG];
  int pbi = -1;
  int pbj = -1;

  int checks = 0;
  int fails  = 0;
  int dones  = 0;
  int run    = 0;
  int maxrun = 0;
  logic [20:0] exp_q[$];

  function automatic logic [7:0] dbyte(int i, int j, int o);
    return 8'(i * 37 + j * 11 + o * 5 + (o >> 3));
  endfunction

  function automatic logic [7:0] psum(int i, int j);
    logic [7:0] s = 8'h00;
    for (int o = 0; o < 256; o++) s = s + dbyte(i, j, o);
    return s;
  endfunction

  function automatic logic [7:0] hbyte(int i, int k);
    logic [7:0] s;
    int j;
    case (k)
      0: return 8'hA0 + 8'(i);
      1: return 8'hB0 + 8'(i);
      2: return 8'hC0 + 8'(i);
      3: return 8'(npgs[i]);
      4: return 8'h3C;
      5: return lid[i];
      6: return 8'h5A;
      7: begin
        s = (8'hA0 + 8'(i)) + (8'hB0 + 8'(i)) + (8'hC0 + 8'(i)) + 8'(npgs[i])
            + 8'h3C + lid[i] + 8'h5A;
        return 8'h55 - s + hbad[i];
      end
      default: begin
        if (k >= 16 && k < 56) return dsc[i][k-16];
        if (k >= 64 && k < 104) begin
          j = k - 64;
          s = 8'h55 - dsc[i][j] - psum(i, j);
          if (i == pbi && j == pbj) s = s + 8'h01;
          return s;
        end
        return 8'hFF;
      end
    endcase
  endfunction

  function automatic logic [7:0] mem_byte(int a);
    int i = a / IMGB;
    int o = a % IMGB;
    if (i >= NIMG) return 8'h00;
    if (o < 8192) return dbyte(i, o >> 8, o & 255);
    return hbyte(i, o - 8192);
  endfunction

  // Image memory, one cycle read latency
  always @(posedge clk) img_rdata <= mem_byte(int'(img_addr));

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  // Monitor: pops expected writes and compares
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) dones++;
      if (ram_we) begin
        run++;
        if (run > maxrun) maxrun = run;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3/R5 unexpected write", int'({ram_addr, ram_wdata}), 0);
        end else begin
          logic [20:0] e;
          e = exp_q.pop_front();
          chk({ram_addr, ram_wdata} == e, "R3 write addr/data",
              int'({ram_addr, ram_wdata}), int'(e));
        end
      end else begin
        run = 0;
      end
    end
  end

  task automatic push_image(input int e);
    int np = (npgs[e] > 32) ? 32 : npgs[e];
    for (int j = 0; j < np; j++) begin
      logic [1:0] bk = dsc[e][j][1:0];
      logic [2:0] pg = dsc[e][j][4:2];
      if (bk != 2'b11)
        for (int o = 0; o < 256; o++)
          exp_q.push_back({bk, pg, 8'(o), dbyte(e, j, o)});
    end
  endtask

  task automatic run_load(input logic [7:0] id, input int nimg, input int ei,
                          input bit enf, input bit ehb, input bit epb,
                          input bit mid, input int minrun, input string rq);
    int n = 0;
    if (!enf) push_image(ei);
    dones  = 0;
    maxrun = 0;
    @(negedge clk);
    load_id = id; num_images = 3'(nimg); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, {rq, " R8 busy after start"}, int'(busy), 1);
    if (mid) begin
      repeat (15) @(negedge clk);
      chk(busy == 1'b1, "R8 busy mid-load", int'(busy), 1);
      load_id = 8'h33; num_images = 3'd4; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done && n < 40000) begin
      @(negedge clk);
      n++;
    end
    chk(done == 1'b1, {rq, " R8 done seen"}, int'(done), 1);
    chk(not_found == enf, {rq, " R7 not_found"}, int'(not_found), int'(enf));
    chk(hdr_bad == ehb, {rq, " R2 hdr_bad"}, int'(hdr_bad), int'(ehb));
    chk(page_bad == epb, {rq, " R4 page_bad"}, int'(page_bad), int'(epb));
    if (!enf) begin
      chk(hdr_p0 == 8'hA0 + 8'(ei), {rq, " R6 hdr_p0"}, int'(hdr_p0), int'(8'hA0 + 8'(ei)));
      chk(hdr_p1 == 8'hB0 + 8'(ei), {rq, " R6 hdr_p1"}, int'(hdr_p1), int'(8'hB0 + 8'(ei)));
      chk(hdr_p2 == 8'hC0 + 8'(ei), {rq, " R6 hdr_p2"}, int'(hdr_p2), int'(8'hC0 + 8'(ei)));
    end
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, {rq, " R8 idle after done"}, int'(busy), 0);
    chk(exp_q.size() == 0, {rq, " R3 all writes seen"}, exp_q.size(), 0);
    chk(dones == 1, {rq, " R8 single done"}, dones, 1);
    if (minrun > 0) chk(maxrun == minrun, {rq, " R9 write burst"}, maxrun, minrun);
    exp_q.delete();
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R8 watchdog expired act=0 exp=1");
    summary();
    $finish;
  end

  initial begin
    lid[0] = 8'h10; lid[1] = 8'h21; lid[2] = 8'h21; lid[3] = 8'h33;
    npgs[0] = 3; npgs[1] = 2; npgs[2] = 4; npgs[3] = 1;
    for (int i = 0; i < NIMG; i++) begin
      hbad[i] = 8'h00;
      for (int j = 0; j < 40; j++)
        dsc[i][j] = {3'(j), 3'((3 * j + i) % 8), 2'((i + j) % 3)};
    end

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(busy == 0 && done == 0 && ram_we == 0, "R11 reset control", int'({busy, done, ram_we}), 0);
    chk(not_found == 0 && hdr_bad == 0 && page_bad == 0, "R11 reset flags",
        int'({not_found, hdr_bad, page_bad}), 0);
    chk({hdr_p0, hdr_p1, hdr_p2} == 24'h0, "R11 reset params", int'({hdr_p0, hdr_p1, hdr_p2}), 0);

    // R3 R6 R9: first image, mixed banks
    run_load(8'h10, 4, 0, 0, 0, 0, 0, 256, "R3");
    // R1: doubled load number resolves to the lower image
    run_load(8'h21, 4, 1, 0, 0, 0, 0, 256, "R1");
    // R1 R7: match sits beyond num_images
    run_load(8'h33, 3, 0, 1, 0, 0, 0, 0, "R7 limited scan");
    // R7: zero images
    run_load(8'h10, 0, 0, 1, 0, 0, 0, 0, "R7 zero images");
    // R5: middle page aimed at bank 3
    dsc[0][1][1:0] = 2'b11;
    run_load(8'h10, 4, 0, 0, 0, 0, 0, 256, "R5");
    dsc[0][1][1:0] = 2'b01;
    // R4: bad page checksum, still copied
    pbi = 0; pbj = 2;
    run_load(8'h10, 4, 0, 0, 0, 1, 0, 256, "R4");
    pbi = -1; pbj = -1;
    // R2: bad header checksum, load continues
    hbad[3] = 8'h01;
    run_load(8'h33, 4, 3, 0, 1, 0, 0, 256, "R2");
    hbad[3] = 8'h00;
    // R8: start while busy is ignored
    run_load(8'h21, 4, 1, 0, 0, 0, 1, 256, "R8");
    // R6: zero page count
    lid[2] = 8'h44; npgs[2] = 0;
    run_load(8'h44, 4, 2, 0, 0, 0, 0, 0, "R6 empty");
    // R10: page count above 32
    npgs[3] = 40;
    run_load(8'h33, 4, 3, 0, 0, 0, 0, 256, "R10");

    summary();
    $finish;
  end

endmodule